// File: doc/BRIEF.md
# SPI Bit-Clock Divider

This block derives the bit timing of a serial peripheral interface shift engine from the module clock. It does not output a gated clock. It outputs two single-cycle enable strobes, one for the leading edge and one for the trailing edge of each bit clock period, and a registered square wave that follows the bit clock phase. The shift engine uses the square wave as a reference and applies its own polarity.

A 13-bit control word sets the rate. Bit 12 picks one of two divide laws, and each law has its own field in the word. With bit 12 set, the linear law uses bits 7:0 as `n`, and the bit clock is the module clock divided by 2×(n+1). With bit 12 clear, the power-of-two law uses bits 11:8 as `n`, and the bit clock is the module clock divided by 2^n. A power-of-two value of 0 behaves like 1, so the output is always a symmetric square wave. The fastest setting gives half the module clock.

The engine raises `run_i` while it shifts. While `run_i` is low, the divider holds the idle phase and keeps reloading its half-period count, so the first edge after a start comes one full half-period later. The control word is sampled only at half-period boundaries, so a change made during a transfer never produces a runt pulse. Working out the best setting for a target frequency is left to software.

Top module: `spi_clkdiv`

## Requirements
- R1: During reset and after it, with `run_i` low, `sclk_ref_o`, `lead_stb_o` and `trail_stb_o` are all 0.
- R2: With bit 12 set, each half-period lasts n+1 module clock cycles, where n is bits 7:0. Consecutive strobes are n+1 cycles apart.
- R3: With bit 12 clear and n = bits 11:8 at 1 or more, each half-period lasts 2^(n-1) cycles.
- R4: With bit 12 clear and bits 11:8 equal to 0, each half-period lasts 1 cycle, the same as n = 1.
- R5: With the linear law and n = 0, a strobe appears on every cycle and `sclk_ref_o` toggles every cycle, which is half the module clock.
- R6: Each half-period produces exactly one strobe. The strobes alternate, starting with the leading one. `lead_stb_o` is high in the same cycle that `sclk_ref_o` goes from 0 to 1, and `trail_stb_o` in the cycle it goes from 1 to 0. The two strobes are never high together.
- R7: After at least one cycle with `run_i` low, the first strobe appears one full half-period after the first clock edge that samples `run_i` high. When `run_i` is low, the cycle after shows no strobes and `sclk_ref_o` at 0.
- R8: A control word change during a half-period leaves that half-period's length unchanged. The new setting applies from the next half-period onward.
- R9: The field of the law that is not selected has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High while the shift engine is transferring |
| cfg_word_i | input | 13 | Control word: law select in bit 12, power-of-two n in bits 11:8, linear n in bits 7:0 |
| sclk_ref_o | output | 1 | Bit clock phase reference, idle level 0 |
| lead_stb_o | output | 1 | One-cycle strobe at each leading bit clock edge |
| trail_stb_o | output | 1 | One-cycle strobe at each trailing bit clock edge |

## Verification
With a half-period of H cycles, a strobe is registered on the H-th rising edge at which `run_i` is sampled high. Each following strobe lands exactly H edges after the previous one. The bench drives inputs and samples outputs on the falling edge and keeps a cycle counter that advances on each rising edge, so every check compares counter differences against H with no slack. For a mid-run setting change, the checks expect the old H for the half-period already under way and the new H only from the boundary after it.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    // Divide law chosen by the select bit of the control word
    typedef enum logic {
        DIV_POW2   = 1'b0,
        DIV_LINEAR = 1'b1
    } div_law_e;

endpackage

// File: rtl/spi_clkdiv_decode.sv
module spi_clkdiv_decode
    import spi_clkdiv_pkg::*;
#(
    parameter int CFG_W   = 13,
    parameter int LIN_LSB = 0,
    parameter int LIN_W   = 8,
    parameter int POW_LSB = 8,
    parameter int POW_W   = 4,
    parameter int SEL_BIT = 12,
    parameter int CNT_W   = 14
) (
    input  logic [CFG_W-1:0] cfg_word_i,
    output logic [CNT_W-1:0] reload_o
);

    div_law_e               law;
    logic [LIN_W-1:0]       lin_n;
    logic [POW_W-1:0]       pow_n;
    logic [POW_W-1:0]       pow_shamt;
    logic [CNT_W-1:0]       lin_reload;
    logic [CNT_W-1:0]       pow_reload;
    logic [CNT_W-1:0]       unit;

    always_comb begin
        law   = div_law_e'(cfg_word_i[SEL_BIT]);
        lin_n = cfg_word_i[LIN_LSB +: LIN_W];
        pow_n = cfg_word_i[POW_LSB +: POW_W];
        unit  = {{(CNT_W-1){1'b0}}, 1'b1};

        // Linear law: half-period of n+1 cycles, so the count reloads with n
        lin_reload            = '0;
        lin_reload[LIN_W-1:0] = lin_n;

        // Power-of-two law: half-period of 2^(n-1) cycles, n of 0 taken as 1.
        // A shift equal to CNT_W wraps to 0 and the subtraction yields all ones.
        pow_shamt  = (pow_n == '0) ? '0 : pow_n - 1'b1;
        pow_reload = (unit << pow_shamt) - unit;

        reload_o = (law == DIV_LINEAR) ? lin_reload : pow_reload;
    end

endmodule

// File: rtl/spi_clkdiv_counter.sv
module spi_clkdiv_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    // The count reaches zero on the last cycle of a half-period
    assign tick_o = run_i && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            // Idle: keep loading so a start sees a full half-period
            st_d.cnt = reload_i;
        end else if (st_q.cnt == '0) begin
            // Boundary: the only point where a new setting is taken
            st_d.cnt = reload_i;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A running count below zero-crossing must step down by exactly one
    AST_CNT_STEPS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !tick_o) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)) else $error("count step"); // R2

endmodule

// File: rtl/spi_clkdiv_phase.sv
module spi_clkdiv_phase (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic tick_i,
    output logic phase_o,
    output logic lead_o,
    output logic trail_o
);

    typedef struct packed {
        logic phase;
        logic lead;
        logic trail;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.phase = 1'b0;
            st_d.lead  = 1'b0;
            st_d.trail = 1'b0;
        end else begin
            st_d.lead  = tick_i && !st_q.phase;
            st_d.trail = tick_i &&  st_q.phase;
            st_d.phase = tick_i ? !st_q.phase : st_q.phase;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign lead_o  = st_q.lead;
    assign trail_o = st_q.trail;

    // Every boundary from the counter yields exactly one strobe
    AST_TICK_MAKES_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> (lead_o ^ trail_o)) else $error("tick without strobe"); // R6

    // No strobe without a boundary
    AST_NO_STRAY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> (!lead_o && !trail_o)) else $error("stray strobe"); // R6

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
    import spi_clkdiv_pkg::*;
#(
    parameter int CFG_W   = 13,
    parameter int LIN_LSB = 0,
    parameter int LIN_W   = 8,
    parameter int POW_LSB = 8,
    parameter int POW_W   = 4,
    parameter int SEL_BIT = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CFG_W-1:0] cfg_word_i,
    output logic             sclk_ref_o,
    output logic             lead_stb_o,
    output logic             trail_stb_o
);

    // Largest power-of-two shift is 2^POW_W - 2, so its count needs that many bits
    localparam int POW_SHIFT_MAX = (1 << POW_W) - 2;
    localparam int CNT_W = (LIN_W > POW_SHIFT_MAX) ? LIN_W : POW_SHIFT_MAX;

    logic [CNT_W-1:0] reload;
    logic             tick;

    spi_clkdiv_decode #(
        .CFG_W   (CFG_W),
        .LIN_LSB (LIN_LSB),
        .LIN_W   (LIN_W),
        .POW_LSB (POW_LSB),
        .POW_W   (POW_W),
        .SEL_BIT (SEL_BIT),
        .CNT_W   (CNT_W)
    ) u_decode (
        .cfg_word_i (cfg_word_i),
        .reload_o   (reload)
    );

    spi_clkdiv_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_i),
        .reload_i (reload),
        .tick_o   (tick)
    );

    spi_clkdiv_phase u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_i),
        .tick_i  (tick),
        .phase_o (sclk_ref_o),
        .lead_o  (lead_stb_o),
        .trail_o (trail_stb_o)
    );

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lead_stb_o && trail_stb_o)) else $error("both strobes"); // R6

    AST_LEAD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lead_stb_o |-> (sclk_ref_o && !$past(sclk_ref_o))) else $error("lead misplaced"); // R6

    AST_TRAIL_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trail_stb_o |-> (!sclk_ref_o && $past(sclk_ref_o))) else $error("trail misplaced"); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!lead_stb_o && !trail_stb_o && !sclk_ref_o)) else $error("idle not quiet"); // R7

    AST_SCLK_MOVES_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sclk_ref_o) |-> (lead_stb_o || trail_stb_o || !$past(run_i))) else $error("sclk runt"); // R6

endmodule

// File: tb/spi_clkdiv_bench.sv
module spi_clkdiv_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 20000;

    logic        clk;
    logic        rst_n;
    logic        run;
    logic [12:0] cfg;
    logic        sclk_ref;
    logic        lead_stb;
    logic        trail_stb;

    int cyc;
    int checks;
    int errors;
    bit finished;

    spi_clkdiv u_spi_clkdiv (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .run_i       (run),
        .cfg_word_i  (cfg),
        .sclk_ref_o  (sclk_ref),
        .lead_stb_o  (lead_stb),
        .trail_stb_o (trail_stb)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    initial cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Linear law: select bit 12 set, n in 7:0; junk goes to 11:8
    function automatic logic [12:0] lin_cfg(int n, int junk);
        lin_cfg = {1'b1, 4'(junk), 8'(n)};
    endfunction

    // Power-of-two law: select bit 12 clear, n in 11:8; junk goes to 7:0
    function automatic logic [12:0] pow_cfg(int n, int junk);
        pow_cfg = {1'b0, 4'(n), 8'(junk)};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_strobe(string req, output int at, output bit is_lead,
                               output bit is_trail, output bit sclk_v);
        at = -1; is_lead = 0; is_trail = 0; sclk_v = 0;
        for (int k = 0; k < WAIT_LIMIT; k++) begin
            @(negedge clk);
            if (lead_stb || trail_stb) begin
                at = cyc; is_lead = lead_stb; is_trail = trail_stb; sclk_v = sclk_ref;
                break;
            end
        end
        if (at < 0) check(0, req, "strobe timeout", 0, 1);
    endtask

    task automatic measure(string req, logic [12:0] w, int h, int pulses);
        int prev, at;
        bit l, t, s;
        @(negedge clk);
        run = 1'b0;
        cfg = w;
        repeat (2) @(negedge clk);
        run = 1'b1;
        prev = cyc;
        for (int i = 0; i < pulses; i++) begin
            wait_strobe(req, at, l, t, s);
            check(at - prev == h, req, "half-period length", at - prev, h);
            check(l == (i % 2 == 0) && !(l && t), "R6", "strobe alternation", {l, t}, (i % 2 == 0) ? 2 : 1);
            check(s == l, "R6", "sclk level at strobe", s, l);
            prev = at;
        end
        @(negedge clk);
        run = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run = 1'b0; cfg = lin_cfg(0, 0);
        repeat (3) @(negedge clk);
        check(!sclk_ref && !lead_stb && !trail_stb, "R1", "outputs in reset",
              {sclk_ref, lead_stb, trail_stb}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!sclk_ref && !lead_stb && !trail_stb, "R1", "outputs after reset",
              {sclk_ref, lead_stb, trail_stb}, 0);
    endtask

    task automatic t_linear();
        measure("R2", lin_cfg(3, 0), 4, 4);
        measure("R2", lin_cfg(10, 0), 11, 3);
        measure("R2", lin_cfg(255, 0), 256, 2);
    endtask

    task automatic t_fastest();
        measure("R5", lin_cfg(0, 0), 1, 6);
    endtask

    task automatic t_pow2();
        measure("R3", pow_cfg(1, 0), 1, 4);
        measure("R3", pow_cfg(3, 0), 4, 4);
        measure("R3", pow_cfg(8, 0), 128, 3);
        measure("R4", pow_cfg(0, 0), 1, 4);
    endtask

    task automatic t_ignore();
        measure("R9", lin_cfg(2, 9), 3, 4);
        measure("R9", pow_cfg(2, 200), 2, 4);
    endtask

    task automatic t_idle();
        int bad, at;
        bit l, t, s;
        @(negedge clk);
        run = 1'b0; cfg = lin_cfg(0, 0);
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (lead_stb || trail_stb || sclk_ref) bad++;
        end
        check(bad == 0, "R7", "activity while idle", bad, 0);
        // Stop in the middle of the high phase
        cfg = lin_cfg(4, 0);
        @(negedge clk);
        run = 1'b1;
        wait_strobe("R7", at, l, t, s);
        check(l && s, "R7", "first strobe is leading", {l, s}, 3);
        run = 1'b0;
        @(negedge clk);
        check(!sclk_ref && !lead_stb && !trail_stb, "R7", "return to idle",
              {sclk_ref, lead_stb, trail_stb}, 0);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (lead_stb || trail_stb || sclk_ref) bad++;
        end
        check(bad == 0, "R7", "activity after stop", bad, 0);
        // Restart gets a full half-period again
        measure("R7", lin_cfg(4, 0), 5, 2);
    endtask

    task automatic t_change();
        int prev, at;
        bit l, t, s;
        @(negedge clk);
        run = 1'b0; cfg = lin_cfg(5, 0);
        repeat (2) @(negedge clk);
        run = 1'b1;
        prev = cyc;
        wait_strobe("R8", at, l, t, s);
        check(at - prev == 6, "R8", "half before change", at - prev, 6);
        prev = at;
        repeat (2) @(negedge clk);
        cfg = lin_cfg(1, 0);
        wait_strobe("R8", at, l, t, s);
        check(at - prev == 6, "R8", "half in progress keeps length", at - prev, 6);
        prev = at;
        wait_strobe("R8", at, l, t, s);
        check(at - prev == 2, "R8", "next half uses new setting", at - prev, 2);
        prev = at;
        wait_strobe("R8", at, l, t, s);
        check(at - prev == 2, "R8", "new setting persists", at - prev, 2);
        @(negedge clk);
        run = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        checks = 0; errors = 0; finished = 0;
        t_reset();
        t_linear();
        t_fastest();
        t_pow2();
        t_ignore();
        t_idle();
        t_change();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
        finish_run();
    end

endmodule